// File: doc/BRIEF.md
# External Bus Yield Controller

This block decides when the processor hands its external memory bus to another bus master. An outside master asks for the bus with an active-low request. The block passes that request through a synchroniser. It waits for any external access in flight to finish, then grants the bus. While the bus is granted, it turns off the address, data and strobe drivers and holds the core or lets it run.

The memory access sequencer reports two things to this block: whether an access is busy, and whether the current cycle is the last one of that access. The core's instruction logic reports whether it wants an external access. The block returns a stall to the sequencer, so that no new access starts once a grant is on its way. Because of this stall, the grant can fall between two accesses of one instruction.

With go mode set, the core keeps running during a grant and stops only when it needs the external bus. The block has its own reset, separate from the processor reset. Because of this, requests are still honoured while the processor sits in reset or is booting.

Top module: `extbus_yield_ctrl`

## Requirements
- R1: After block reset (`rst_n` low), `bus_grant_n` is 1, `drv_en_o` is 1 and `acc_stall_o` is 0, and `core_halt_o` equals `core_rst_i`.
- R2: The request is active low and passes through SYNC_STAGES flops (default 2). With no access busy, `bus_grant_n` goes to 0 on the (SYNC_STAGES+1)th rising edge after `bus_req_n` is first sampled low.
- R3: While an access is busy (`acc_busy_i`=1), no grant is given. If the synchronised request is present, the grant is asserted in the cycle after the cycle in which `acc_done_i` is 1.
- R4: `acc_stall_o` is 1 whenever the synchronised request is present or the bus is granted. The sequencer must start no new access while it is 1, so the bus can be granted between two accesses of one instruction.
- R5: With `go_mode_i`=0, `core_halt_o` is 1 in every cycle the bus is granted.
- R6: With `go_mode_i`=1 and the bus granted, `core_halt_o` equals `acc_want_i`: the core runs until it needs an external access.
- R7: After `bus_req_n` returns high, `bus_grant_n` returns to 1 on the (SYNC_STAGES+1)th rising edge. At the same time `drv_en_o` returns to 1 and `core_halt_o` and `acc_stall_o` drop.
- R8: While `core_rst_i` is 1, `core_halt_o` is 1, and requests are still granted and released with the timing of R2 and R7.
- R9: `drv_en_o` is 0 exactly in the cycles where `bus_grant_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, active low, asynchronous |
| bus_req_n | input | 1 | Bus request from the outside master, active low, asynchronous |
| go_mode_i | input | 1 | 1: core keeps running while the bus is granted |
| core_rst_i | input | 1 | Processor is held in reset |
| acc_busy_i | input | 1 | An external access occupies the bus this cycle |
| acc_done_i | input | 1 | This is the last cycle of the busy access |
| acc_want_i | input | 1 | Core needs an external access |
| bus_grant_n | output | 1 | Bus grant, active low |
| drv_en_o | output | 1 | 1: drive address, data and strobes; 0: three-state |
| core_halt_o | output | 1 | Stop the core |
| acc_stall_o | output | 1 | Sequencer must not begin a new access |

## Verification
The assertions assume that the sequencer obeys the stall. In any cycle where the bus is granted, `acc_busy_i` is 0, and `acc_done_i` is 1 only while `acc_busy_i` is 1. The bench follows these rules in every scenario. It raises the busy flag only before it drives the request, or while the request has not yet passed the synchroniser. It clears busy and done in the cycle the grant appears. It changes the request only at falling clock edges, so the synchroniser latency is fixed and each grant edge can be predicted exactly.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

    typedef struct packed {
        logic granted;
        logic grant_n;
        logic drv_en;
    } grant_st_t;

    localparam grant_st_t GRANT_RST = '{granted: 1'b0, grant_n: 1'b1, drv_en: 1'b1};

endpackage

// File: rtl/extbus_req_sync.sv
module extbus_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_i,
    output logic req_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d;
    logic [LAST:0] chain_q;

    // Stage 0 takes the inverted raw pin; each later stage takes the one before it.
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_comb chain_d[i] = ~req_n_i;
        end else begin : g_tail
            always_comb chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign req_o = chain_q[LAST];

endmodule

// File: rtl/extbus_grant_ctl.sv
module extbus_grant_ctl
    import extbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic acc_busy_i,
    input  logic acc_done_i,
    output logic granted_o,
    output logic grant_n_o,
    output logic drv_en_o
);
    grant_st_t st_d;
    grant_st_t st_q;
    logic      bus_free;

    // The bus is free when nothing is busy, or when the busy access ends in this cycle.
    always_comb begin
        bus_free = !acc_busy_i || acc_done_i;
        st_d     = st_q;
        if (st_q.granted) begin
            st_d.granted = req_i;
        end else begin
            st_d.granted = req_i && bus_free;
        end
        st_d.grant_n = !st_d.granted;
        st_d.drv_en  = !st_d.granted;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GRANT_RST;
        else        st_q <= st_d;
    end

    assign granted_o = st_q.granted;
    assign grant_n_o = st_q.grant_n;
    assign drv_en_o  = st_q.drv_en;

    // R3: a grant only begins when the bus was free in the previous cycle.
    a_r3_grant_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.granted) |-> $past(!acc_busy_i || acc_done_i));

    // R2: a grant only begins if the synchronised request was present.
    a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.granted) |-> $past(req_i));

    // R7: a dropped request ends the grant on the next edge.
    a_r7_release_next: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.granted && !req_i) |=> !st_q.granted);

    // Input rule: the sequencer leaves the bus quiet while it is granted.
    a_r4_quiet_when_granted: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.granted |-> !acc_busy_i);

endmodule

// File: rtl/extbus_core_gate.sv
module extbus_core_gate (
    input  logic granted_i,
    input  logic req_i,
    input  logic go_mode_i,
    input  logic core_rst_i,
    input  logic acc_want_i,
    output logic core_halt_o,
    output logic acc_stall_o
);
    logic hold_for_bus;

    always_comb begin
        hold_for_bus = granted_i && (!go_mode_i || acc_want_i);
        core_halt_o  = core_rst_i || hold_for_bus;
        acc_stall_o  = req_i || granted_i;
    end

endmodule

// File: rtl/extbus_yield_ctrl.sv
module extbus_yield_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_req_n,
    input  logic go_mode_i,
    input  logic core_rst_i,
    input  logic acc_busy_i,
    input  logic acc_done_i,
    input  logic acc_want_i,
    output logic bus_grant_n,
    output logic drv_en_o,
    output logic core_halt_o,
    output logic acc_stall_o
);
    logic req_sync;
    logic granted;

    extbus_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n_i (bus_req_n),
        .req_o   (req_sync)
    );

    extbus_grant_ctl u_grant (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_sync),
        .acc_busy_i (acc_busy_i),
        .acc_done_i (acc_done_i),
        .granted_o  (granted),
        .grant_n_o  (bus_grant_n),
        .drv_en_o   (drv_en_o)
    );

    extbus_core_gate u_gate (
        .granted_i   (granted),
        .req_i       (req_sync),
        .go_mode_i   (go_mode_i),
        .core_rst_i  (core_rst_i),
        .acc_want_i  (acc_want_i),
        .core_halt_o (core_halt_o),
        .acc_stall_o (acc_stall_o)
    );

    // R9: the drivers are off exactly while the grant pin is active.
    a_r9_drv_tracks_grant: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en_o == bus_grant_n);

    // R5: without go mode, a granted bus stops the core.
    a_r5_halt_when_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_grant_n && !go_mode_i) |-> core_halt_o);

    // R6: in go mode, the core runs while the bus is granted unless it wants the bus.
    a_r6_go_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_grant_n && go_mode_i && !acc_want_i && !core_rst_i) |-> !core_halt_o);

    // R8: processor reset always stops the core.
    a_r8_reset_halts: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_i |-> core_halt_o);

    // R4: no new access may start while the bus is granted.
    a_r4_stall_when_granted: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_grant_n |-> acc_stall_o);

endmodule

// File: tb/extbus_yield_ctrl_tb.sv
module extbus_yield_ctrl_tb;

    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic bus_req_n, go_mode_i, core_rst_i, acc_busy_i, acc_done_i, acc_want_i;
    logic bus_grant_n, drv_en_o, core_halt_o, acc_stall_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    extbus_yield_ctrl #(.SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n), .go_mode_i(go_mode_i),
        .core_rst_i(core_rst_i), .acc_busy_i(acc_busy_i), .acc_done_i(acc_done_i),
        .acc_want_i(acc_want_i), .bus_grant_n(bus_grant_n), .drv_en_o(drv_en_o),
        .core_halt_o(core_halt_o), .acc_stall_o(acc_stall_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Request with no access busy, then release.
    task automatic t_idle_grant();
        bus_req_n = 1'b0;
        step(SYNC);
        chk("R2 grant not yet", bus_grant_n, 1'b1);
        chk("R4 stall on synced req", acc_stall_o, 1'b1);
        step(1);
        chk("R2 grant asserted", bus_grant_n, 1'b0);
        chk("R9 drivers off", drv_en_o, 1'b0);
        chk("R5 halt while granted", core_halt_o, 1'b1);
        bus_req_n = 1'b1;
        step(SYNC);
        chk("R7 grant held during sync", bus_grant_n, 1'b0);
        step(1);
        chk("R7 grant released", bus_grant_n, 1'b1);
        chk("R7 drivers back", drv_en_o, 1'b1);
        chk("R7 halt dropped", core_halt_o, 1'b0);
        chk("R7 stall dropped", acc_stall_o, 1'b0);
    endtask

    // Request arrives while an access with wait states is busy.
    task automatic t_busy_grant();
        acc_busy_i = 1'b1;
        bus_req_n  = 1'b0;
        step(6);
        chk("R3 no grant mid access", bus_grant_n, 1'b1);
        chk("R4 stall during access", acc_stall_o, 1'b1);
        acc_done_i = 1'b1;
        step(1);
        chk("R3 grant after last cycle", bus_grant_n, 1'b0);
        acc_busy_i = 1'b0;
        acc_done_i = 1'b0;
        bus_req_n  = 1'b1;
        step(SYNC + 1);
        chk("R7 release after busy case", bus_grant_n, 1'b1);
    endtask

    // Two back-to-back accesses; grant falls between them.
    task automatic t_between();
        acc_busy_i = 1'b1;
        acc_done_i = 1'b1;
        bus_req_n  = 1'b0;
        step(1);
        acc_done_i = 1'b0;
        acc_busy_i = 1'b0;
        acc_want_i = 1'b1;
        step(SYNC);
        chk("R4 second access held", acc_stall_o, 1'b1);
        chk("R4 grant between accesses", bus_grant_n, 1'b0);
        bus_req_n = 1'b1;
        step(SYNC + 1);
        chk("R4 bus returned", acc_stall_o, 1'b0);
        acc_want_i = 1'b0;
    endtask

    // Go mode: core runs until it wants the bus.
    task automatic t_go_mode();
        go_mode_i = 1'b1;
        bus_req_n = 1'b0;
        step(SYNC + 1);
        chk("R6 granted in go mode", bus_grant_n, 1'b0);
        chk("R6 core runs", core_halt_o, 1'b0);
        acc_want_i = 1'b1;
        #1;
        chk("R6 halt on bus need", core_halt_o, 1'b1);
        acc_want_i = 1'b0;
        bus_req_n  = 1'b1;
        step(SYNC + 1);
        chk("R7 release in go mode", bus_grant_n, 1'b1);
        go_mode_i = 1'b0;
    endtask

    // Processor reset: halt held, grant still works.
    task automatic t_core_reset();
        core_rst_i = 1'b1;
        step(1);
        chk("R8 halt in reset", core_halt_o, 1'b1);
        bus_req_n = 1'b0;
        step(SYNC + 1);
        chk("R8 grant in reset", bus_grant_n, 1'b0);
        bus_req_n = 1'b1;
        step(SYNC + 1);
        chk("R8 release in reset", bus_grant_n, 1'b1);
        chk("R8 halt still held", core_halt_o, 1'b1);
        core_rst_i = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        bus_req_n = 1'b1; go_mode_i = 1'b0; core_rst_i = 1'b0;
        acc_busy_i = 1'b0; acc_done_i = 1'b0; acc_want_i = 1'b0;
        step(3);
        chk("R1 grant idle", bus_grant_n, 1'b1);
        chk("R1 drivers on", drv_en_o, 1'b1);
        chk("R1 no stall", acc_stall_o, 1'b0);
        chk("R1 no halt", core_halt_o, 1'b0);
        rst_n = 1'b1;
        step(2);
        t_idle_grant();
        step(2);
        t_busy_grant();
        step(2);
        t_between();
        step(2);
        t_go_mode();
        step(2);
        t_core_reset();
        step(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule